// File: doc/BRIEF.md
# Frame-Synced Parallel Data Port

This block is a general-purpose parallel port that runs on an external port clock. It moves up to 16 bits on each clock. In receive mode it drives the sampled pin word onto a valid/ready output stream. In transmit mode it takes words from a valid/ready input stream and drives them onto the pins. Transfers are grouped into lines and frames by one to three frame-sync signals. The port generates these syncs itself (internal mode) or follows syncs supplied by the attached device (external mode). A programmable number of clocks may separate a line sync from the first word of that line. After that gap the port moves exactly the configured number of samples. It then waits for the next line sync.

The sequencer is a four-state machine. ST_IDLE is held while the port is disabled, and enabling it takes the transition IDLE→WAIT. In ST_WAIT the port waits for a line sync. On a sync it takes WAIT→DELAY when the delay is non-zero. With a zero delay it takes WAIT→XFER, moving the first word in the sync cycle itself, or WAIT→WAIT when a line is a single sample. ST_DELAY counts out the gap and takes DELAY→XFER, or DELAY→WAIT for a one-sample line, on the clock that moves the first word. ST_XFER moves one word per clock and takes XFER→WAIT on the last word of the line. Dropping the enable takes any state straight back to ST_IDLE.

Stream stalls do not stop the port. A missed handshake is recorded in a sticky flag, and the line carries on. The configuration is expected to be held stable while the port is enabled.

Top module: `fsync_pport`

## Requirements
- R1: After reset, and while cfg_enable is low, m_valid, s_ready, fs_out, pd_out, pd_oe, overrun and underrun are all 0, whatever fs_in does.
- R2: Pin bits at or above cfg_width are forced to 0 on m_data and on pd_out. A cfg_width of 0, or of 16 and above, selects the full 16 bits.
- R3: With internal syncs, fs_out[0] pulses for one clock on the first clock after enabling. It then pulses again every cfg_delay + cfg_line_len clocks.
- R4: The first word of a line moves cfg_delay clocks after the sync cycle. A delay of 0 moves it in the sync cycle itself.
- R5: Exactly cfg_line_len words move per line, one per clock. The port then waits for the next line sync.
- R6: With internal syncs, fs_out[1] pulses together with fs_out[0] on the first line of every group of cfg_frame_lines lines, when cfg_num_syncs is 2 or 3. fs_out[2] is a level that toggles after every fs_out[1] pulse, when cfg_num_syncs is 3. Unused sync outputs stay 0, and cfg_num_syncs of 0 or 1 means one sync.
- R7: With external syncs, a line starts only on a rising edge of fs_in[0] seen while waiting. A level held high does not start further lines, and fs_out stays 0.
- R8: With external syncs and cfg_num_syncs of 2 or 3, fs_in[0] edges are ignored until a rising edge of fs_in[1] arms the port. The arm then allows cfg_frame_lines lines. Edges of fs_in[1] and fs_in[0] on the same clock start a line.
- R9: With external syncs and cfg_num_syncs of 3, fs_in[0] edges are recognised only while fs_in[2] is high.
- R10: In receive mode (cfg_tx = 0) each moved word appears on m_data with m_valid high. If m_ready is low on such a clock, overrun goes high on the next clock and stays high until reset, and the line continues.
- R11: In transmit mode (cfg_tx = 1) pd_oe is high while enabled, and s_ready is high on every transfer clock, with pd_out = s_data. If s_valid is low on such a clock, pd_out is 0 and underrun goes high on the next clock and stays high until reset, and the line continues.
- R12: Dropping cfg_enable stops transfers at once. Re-enabling restarts the line and frame counting from the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Port enable |
| cfg_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_ext_sync | input | 1 | 1 = syncs come from fs_in, 0 = syncs generated |
| cfg_num_syncs | input | 2 | Number of sync levels (0/1 = one, 2, 3) |
| cfg_width | input | 5 | Active data bits (0 = full width) |
| cfg_delay | input | 8 | Clocks from line sync to first word |
| cfg_line_len | input | 12 | Words per line |
| cfg_frame_lines | input | 10 | Lines per frame |
| fs_in | input | 3 | External syncs: [0] line, [1] frame, [2] gate |
| fs_out | output | 3 | Generated syncs: [0] line, [1] frame, [2] field level |
| pd_in | input | 16 | Pin data in (receive) |
| pd_out | output | 16 | Pin data out (transmit) |
| pd_oe | output | 1 | Pin output enable |
| s_data | input | 16 | Transmit stream data |
| s_valid | input | 1 | Transmit stream valid |
| s_ready | output | 1 | Transmit stream ready (word taken) |
| m_data | output | 16 | Receive stream data |
| m_valid | output | 1 | Receive stream valid |
| m_ready | input | 1 | Receive stream ready |
| overrun | output | 1 | Sticky: receive word not accepted |
| underrun | output | 1 | Sticky: transmit word not available |

## Verification
The bench aims at the off-by-one edges of the sequencer. With a zero delay the word must move in the sync cycle itself, and a design that always waits one clock would shift every line late. The line end would then bleed into the next line period. A held-high external sync must not retrigger, and a level-sensitive detector would start extra lines. The frame arm must expire after the configured line count and must also accept a frame edge on the same clock as the line edge. A wrong arm count, or a missing same-cycle case, would pass or drop lines. Stalls during a line must set the sticky flag and leave the word count intact. Aborting and re-enabling must restart the frame counter, or the frame sync would appear on the wrong line.

// File: rtl/fsync_pport_pkg.sv
package fsync_pport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_XFER  = 2'd3
    } pp_state_e;

endpackage

// File: rtl/fsync_pport_sync.sv
module fsync_pport_sync #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ext,
    input  logic [1:0]        nsync,
    input  logic [2:0]        fs_in,
    input  logic              waiting,
    input  logic [LINE_W-1:0] frame_lines,
    output logic              hit,
    output logic [2:0]        fs_out
);

    logic [2:0]        prev_q;
    logic [2:0]        rise;
    logic              armed_q;
    logic              field_q;
    logic [LINE_W-1:0] lcnt_q;
    logic [LINE_W-1:0] lbase;
    logic              lwrap;
    logic              lvl2, lvl3, gate, arm_now, fs2_int;

    assign rise    = fs_in & ~prev_q;
    assign lvl2    = (nsync >= 2'd2);
    assign lvl3    = (nsync == 2'd3);
    assign gate    = !lvl3 || fs_in[2];
    assign arm_now = !lvl2 || armed_q || rise[1];
    assign hit     = waiting && (ext ? (rise[0] && arm_now && gate) : 1'b1);

    // A frame edge restarts the line count in external mode
    assign lbase   = (ext && lvl2 && rise[1]) ? '0 : lcnt_q;
    assign lwrap   = ({1'b0, lbase} + (LINE_W+1)'(1)) >= {1'b0, frame_lines};
    assign fs2_int = !ext && lvl2 && hit && (lcnt_q == '0);

    assign fs_out  = {(!ext && lvl3 && field_q), fs2_int, (!ext && hit)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            lcnt_q  <= '0;
            armed_q <= 1'b0;
            field_q <= 1'b0;
        end else begin
            prev_q <= fs_in;
            if (!en) begin
                lcnt_q  <= '0;
                armed_q <= 1'b0;
                field_q <= 1'b0;
            end else begin
                if (hit) lcnt_q <= lwrap ? '0 : lbase + LINE_W'(1);
                else     lcnt_q <= lbase;
                armed_q <= (armed_q || (lvl2 && rise[1])) && !(hit && lwrap);
                field_q <= field_q ^ fs2_int;
            end
        end
    end

endmodule

// File: rtl/fsync_pport_seq.sv
module fsync_pport_seq
    import fsync_pport_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic [DLY_W-1:0] delay,
    input  logic [LEN_W-1:0] line_len,
    output logic             waiting,
    output logic             xfer
);

    pp_state_e        state_q, state_d;
    logic [DLY_W-1:0] dcnt_q, dcnt_d;
    logic [LEN_W-1:0] scnt_q, scnt_d;
    logic             single;

    assign single = (line_len <= LEN_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dcnt_q  <= '0;
            scnt_q  <= '0;
        end else begin
            state_q <= state_d;
            dcnt_q  <= dcnt_d;
            scnt_q  <= scnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        dcnt_d  = dcnt_q;
        scnt_d  = scnt_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_WAIT;
                ST_WAIT: begin
                    if (hit) begin
                        if (delay != '0) begin
                            state_d = ST_DELAY;
                            dcnt_d  = DLY_W'(1);
                        end else if (!single) begin
                            state_d = ST_XFER;
                            scnt_d  = LEN_W'(1);
                        end
                    end
                end
                ST_DELAY: begin
                    if (dcnt_q == delay) begin
                        state_d = single ? ST_WAIT : ST_XFER;
                        scnt_d  = LEN_W'(1);
                    end else begin
                        dcnt_d = dcnt_q + DLY_W'(1);
                    end
                end
                ST_XFER: begin
                    if (scnt_q == line_len - LEN_W'(1)) state_d = ST_WAIT;
                    else scnt_d = scnt_q + LEN_W'(1);
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        waiting = en && (state_q == ST_WAIT);
        xfer    = 1'b0;
        if (en) begin
            unique case (state_q)
                ST_IDLE:  xfer = 1'b0;
                ST_WAIT:  xfer = hit && (delay == '0);
                ST_DELAY: xfer = (dcnt_q == delay);
                ST_XFER:  xfer = 1'b1;
                default:  xfer = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fsync_pport.sv
module fsync_pport #(
    parameter  int DATA_W = 16,
    parameter  int DLY_W  = 8,
    parameter  int LEN_W  = 12,
    parameter  int LINE_W = 10,
    localparam int WID_W  = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_tx,
    input  logic              cfg_ext_sync,
    input  logic [1:0]        cfg_num_syncs,
    input  logic [WID_W-1:0]  cfg_width,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [LEN_W-1:0]  cfg_line_len,
    input  logic [LINE_W-1:0] cfg_frame_lines,
    input  logic [2:0]        fs_in,
    output logic [2:0]        fs_out,
    input  logic [DATA_W-1:0] pd_in,
    output logic [DATA_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              overrun,
    output logic              underrun
);

    logic [DATA_W-1:0] mask;
    logic              hit, waiting, xfer, rx_go, tx_go;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (cfg_width == '0) || (WID_W'(i) < cfg_width);
    end

    fsync_pport_sync #(.LINE_W(LINE_W)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (cfg_enable),
        .ext         (cfg_ext_sync),
        .nsync       (cfg_num_syncs),
        .fs_in       (fs_in),
        .waiting     (waiting),
        .frame_lines (cfg_frame_lines),
        .hit         (hit),
        .fs_out      (fs_out)
    );

    fsync_pport_seq #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_enable),
        .hit      (hit),
        .delay    (cfg_delay),
        .line_len (cfg_line_len),
        .waiting  (waiting),
        .xfer     (xfer)
    );

    assign rx_go   = xfer && !cfg_tx;
    assign tx_go   = xfer && cfg_tx;
    assign m_valid = rx_go;
    assign m_data  = rx_go ? (pd_in & mask) : '0;
    assign s_ready = tx_go;
    assign pd_out  = (tx_go && s_valid) ? (s_data & mask) : '0;
    assign pd_oe   = cfg_enable && cfg_tx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            overrun  <= overrun  || (rx_go && !m_ready);
            underrun <= underrun || (tx_go && !s_valid);
        end
    end

endmodule

// File: rtl/fsync_pport_chk.sv
module fsync_pport_chk #(
    parameter  int DATA_W = 16,
    localparam int WID_W  = $clog2(DATA_W) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              cfg_ext_sync,
    input logic [WID_W-1:0]  cfg_width,
    input logic [2:0]        fs_out,
    input logic [DATA_W-1:0] m_data,
    input logic              m_valid,
    input logic              m_ready,
    input logic              s_valid,
    input logic              s_ready,
    input logic              overrun,
    input logic              underrun
);

    logic [DATA_W-1:0] keep;
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            keep[i] = (cfg_width == '0) || (i < int'(cfg_width));
    end

    assert_width_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ((m_data & ~keep) == '0));
    assert_fs2_with_fs1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out[1] |-> fs_out[0]);
    assert_ext_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ext_sync |-> (fs_out == 3'b000));
    assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> overrun);
    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_underrun_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> underrun);
    assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    assert_one_direction_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_valid && s_ready));
    assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (!m_valid && !s_ready && fs_out == 3'b000));

endmodule

bind fsync_pport fsync_pport_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_ext_sync (cfg_ext_sync),
    .cfg_width    (cfg_width),
    .fs_out       (fs_out),
    .m_data       (m_data),
    .m_valid      (m_valid),
    .m_ready      (m_ready),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .overrun      (overrun),
    .underrun     (underrun)
);

// File: tb/fsync_pport_test.sv
`timescale 1ns/1ps
module fsync_pport_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_tx = 1'b0, cfg_ext_sync = 1'b0;
    logic [1:0]  cfg_num_syncs = 2'd1;
    logic [4:0]  cfg_width = 5'd0;
    logic [7:0]  cfg_delay = 8'd0;
    logic [11:0] cfg_line_len = 12'd1;
    logic [9:0]  cfg_frame_lines = 10'd1;
    logic [2:0]  fs_in = 3'b000;
    logic [2:0]  fs_out;
    logic [15:0] pd_in = '0, pd_out, s_data = '0, m_data;
    logic        pd_oe, s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b1;
    logic        overrun, underrun;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fsync_pport uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_tx(cfg_tx),
        .cfg_ext_sync(cfg_ext_sync), .cfg_num_syncs(cfg_num_syncs),
        .cfg_width(cfg_width), .cfg_delay(cfg_delay), .cfg_line_len(cfg_line_len),
        .cfg_frame_lines(cfg_frame_lines), .fs_in(fs_in), .fs_out(fs_out),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .s_data(s_data),
        .s_valid(s_valid), .s_ready(s_ready), .m_data(m_data), .m_valid(m_valid),
        .m_ready(m_ready), .overrun(overrun), .underrun(underrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setup(input logic tx, input logic ext, input logic [1:0] ns,
                         input logic [7:0] dly, input logic [11:0] len,
                         input logic [9:0] fl, input logic [4:0] wid);
        @(negedge clk);
        cfg_enable = 1'b0; rst_n = 1'b0;
        cfg_tx = tx; cfg_ext_sync = ext; cfg_num_syncs = ns; cfg_delay = dly;
        cfg_line_len = len; cfg_frame_lines = fl; cfg_width = wid;
        fs_in = 3'b000; m_ready = 1'b1; s_valid = 1'b1; pd_in = '0; s_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        setup(1'b0, 1'b1, 2'd1, 8'd0, 12'd1, 10'd1, 5'd0);
        for (int c = 0; c < 6; c++) begin
            @(posedge clk); #2 fs_in = (c % 2 == 0) ? 3'b111 : 3'b000; pd_in = 16'hFFFF;
            @(negedge clk);
            chk("R1 idle outputs", {m_valid, s_ready, pd_oe, overrun, underrun, fs_out}, 32'h0);
            chk("R1 idle pd_out", pd_out, 32'h0);
        end
    endtask

    task automatic t_int_rx;
        logic field = 1'b0;
        setup(1'b0, 1'b0, 2'd3, 8'd2, 12'd3, 10'd2, 5'd8);
        cfg_enable = 1'b1;
        for (int c = 0; c < 20; c++) begin
            logic e_fs1, e_fs2, e_v;
            @(posedge clk); #2 pd_in = 16'hA500 | 16'(c);
            @(negedge clk);
            e_fs1 = (c % 5 == 0);
            e_fs2 = e_fs1 && ((c / 5) % 2 == 0);
            e_v   = (c % 5 >= 2);
            chk("R3/R6 internal syncs", fs_out, {field, e_fs2, e_fs1});
            chk("R4/R5 delayed line", m_valid, e_v);
            if (e_v) chk("R2 width 8 rx data", m_data, 32'(c));
            field = field ^ e_fs2;
        end
        chk("R10 no overrun when ready", overrun, 1'b0);
    endtask

    task automatic t_int_tx;
        setup(1'b1, 1'b0, 2'd1, 8'd0, 12'd4, 10'd3, 5'd0);
        cfg_enable = 1'b1;
        for (int c = 0; c < 12; c++) begin
            @(posedge clk); #2 s_data = 16'hC3C0 + 16'(c); s_valid = (c != 5);
            @(negedge clk);
            chk("R4/R5 zero delay continuous", s_ready, 1'b1);
            chk("R3/R6 single sync", fs_out, {2'b00, (c % 4 == 0)});
            chk("R11 pd_out", pd_out, (c == 5) ? 32'h0 : 32'(16'hC3C0 + 16'(c)));
            chk("R11 pd_oe", pd_oe, 1'b1);
            chk("R11 underrun sticky", underrun, (c >= 6));
        end
    endtask

    task automatic t_ext_edge;
        setup(1'b0, 1'b1, 2'd1, 8'd1, 12'd2, 10'd1, 5'd12);
        cfg_enable = 1'b1;
        for (int c = 0; c < 14; c++) begin
            logic e_v;
            @(posedge clk); #2
            fs_in   = ((c >= 2 && c <= 6) || c == 9 || c == 10) ? 3'b001 : 3'b000;
            m_ready = (c != 4);
            pd_in   = 16'hF000 | 16'(c * 17);
            @(negedge clk);
            e_v = (c == 3 || c == 4 || c == 10 || c == 11);
            chk("R7 rising edge only", m_valid, e_v);
            chk("R7 no generated syncs", fs_out, 3'b000);
            if (e_v) chk("R2 width 12 rx data", m_data, 32'(c * 17));
            chk("R10 overrun sticky", overrun, (c >= 5));
        end
    endtask

    task automatic t_ext_two;
        setup(1'b0, 1'b1, 2'd2, 8'd0, 12'd1, 10'd2, 5'd0);
        cfg_enable = 1'b1;
        for (int c = 0; c < 15; c++) begin
            @(posedge clk); #2
            fs_in[0] = (c == 2 || c == 6 || c == 8 || c == 10 || c == 12);
            fs_in[1] = (c == 4 || c == 12);
            @(negedge clk);
            chk("R8 frame arm", m_valid, (c == 6 || c == 8 || c == 12));
        end
    endtask

    task automatic t_ext_three;
        setup(1'b0, 1'b1, 2'd3, 8'd0, 12'd1, 10'd1, 5'd0);
        cfg_enable = 1'b1;
        for (int c = 0; c < 12; c++) begin
            @(posedge clk); #2
            fs_in[0] = (c == 4 || c == 7 || c == 9);
            fs_in[1] = (c == 2);
            fs_in[2] = (c >= 6);
            @(negedge clk);
            chk("R9 gate level", m_valid, (c == 7));
        end
    endtask

    task automatic t_abort;
        setup(1'b0, 1'b0, 2'd2, 8'd0, 12'd8, 10'd4, 5'd0);
        cfg_enable = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #2;
            @(negedge clk);
            chk("R12 running before abort", m_valid, 1'b1);
        end
        cfg_enable = 1'b0;
        #1 chk("R12 stop at once", {m_valid, fs_out}, 32'h0);
        @(posedge clk); #2;
        @(negedge clk);
        chk("R12 idle after abort", {m_valid, fs_out}, 32'h0);
        cfg_enable = 1'b1;
        @(posedge clk); #2;
        @(negedge clk);
        chk("R12 frame restarts", {m_valid, fs_out}, {1'b1, 3'b011});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_int_rx();
        t_int_tx();
        t_ext_edge();
        t_ext_two();
        t_ext_three();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule